// File: doc/BRIEF.md
# DRAM Strobe Select Decoder

The block turns one pair of shared DRAM timing strobes, row and column, into per-bank row selects and per-byte column selects for two banks of 32-bit DRAM. Each bank has 9-bit row and column addresses, so the two banks hold 2 MB in total. The row select only picks the bank. A row-address bit chooses that bank. The block captures this bit on the falling edge of the row strobe and keeps it until the row strobe goes high again. The column selects gate the byte lanes. On a write they act as byte write enables, decoded from the processor transfer size and low offset, or from the half-word offset of a 16-bit chip-side access. On a bridged read they stop the half of the bus that the bridge drives from receiving a column strobe, so that two drivers never contend. Other reads strobe all four lanes.

A refresh is recognised when the column strobe falls while the row strobe is still high, which is column-before-row order. From that point until both strobes are high again, every row and column output follows its timing strobe, whatever the bank or lanes. Address multiplexing, refresh scheduling and the array are outside the block. It samples the strobes on `clk`, which runs faster than the strobes change. All strobes are active low. There is no data flow through the block, so every pin is plain control without a handshake.

Top module: `dram_strobe_sel`

## Requirements
- R1: While the row strobe is high, both row selects are high. On a normal cycle with the row strobe low, only the bank named by `bank_addr` at the row strobe's falling edge has its row select low (bank 0 gives `ras_n`=2'b10 and bank 1 gives 2'b01).
- R2: A change of `bank_addr` while the row strobe stays low has no effect on `ras_n` until the row strobe rises.
- R3: A processor write (`cpu_cycle`=1, `rd`=0) lowers the column selects of the lanes from offset `a_lo` upward. The count is 1, 2, 3 or 4 lanes for `siz` values 01, 10, 11 and 00. Lane i is bit i of `cas_n`.
- R4: A processor write whose span would pass lane 3 is cut at lane 3 and does not wrap. A word at offset 3 gives lane 3 only, and a long at offset 1 gives lanes 1 to 3.
- R5: A chip-side write (`cpu_cycle`=0, `rd`=0) strobes lanes 0 and 1 when `a_lo[1]` is 0 and lanes 2 and 3 when it is 1. `siz` and `a_lo[0]` are ignored.
- R6: A read with `brg_en`=0 strobes all four lanes, whatever the size and offset.
- R7: A read with `brg_en`=1 withholds the column selects of the half named by `brg_half` (0 is lanes 0 and 1, 1 is lanes 2 and 3) and strobes the other half. On writes `brg_en` has no effect.
- R8: While the column strobe is high, all column selects are high.
- R9: A column strobe fall while the row strobe is high starts a refresh. Until both strobes are high again, all row selects follow the row strobe and all column selects follow the column strobe. The next normal cycle decodes as usual.
- R10: During and just after reset, with both strobes high, all outputs are high. The bank register resets to 0 and the refresh state resets to clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for strobe edges |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_tim_n | input | 1 | Shared row timing strobe, active low |
| cas_tim_n | input | 1 | Shared column timing strobe, active low |
| bank_addr | input | BANK_W | Row-address bit(s) that pick the bank |
| cpu_cycle | input | 1 | 1 for a processor access, 0 for a 16-bit chip access |
| rd | input | 1 | 1 for a read, 0 for a write |
| brg_en | input | 1 | Read is bridged between bus halves |
| brg_half | input | 1 | Half driven by the bridge: 0 low, 1 high |
| siz | input | 2 | Processor transfer size: 01 byte, 10 word, 11 three bytes, 00 long |
| a_lo | input | OFF_W | Byte offset within the 32-bit word |
| ras_n | output | NUM_BANKS | Per-bank row selects, active low |
| cas_n | output | LANES | Per-lane column selects, active low |

## Verification
The assertions assume the strobes are steady for at least one `clk` period between changes. They also assume that access attributes and `bank_addr` settle before the row strobe falls, and that `rd`, `brg_en`, `brg_half` and the size fields hold while the column strobe is low. The bench changes every input only on the falling clock edge. In each access it lowers the row strobe first, then the column strobe one cycle later, and releases both before the next access. A refresh is entered only from the idle state, with both strobes high, by lowering the column strobe alone.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam int LANES = 4;
  localparam int OFF_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_LONG   = 2'b00,
    SZ_BYTE   = 2'b01,
    SZ_WORD   = 2'b10,
    SZ_TRIPLE = 2'b11
  } siz_e;
endpackage

// File: rtl/dss_track.sv
module dss_track #(
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_tim_n,
  input  logic              cas_tim_n,
  input  logic [BANK_W-1:0] bank_addr,
  output logic [BANK_W-1:0] bank_sel,
  output logic              refresh
);
  logic              ras_q, cas_q, refr_q;
  logic [BANK_W-1:0] bank_q;
  logic              ras_fall, cas_fall, ref_start, both_idle;

  assign ras_fall  = ras_q & ~ras_tim_n;
  assign cas_fall  = cas_q & ~cas_tim_n;
  assign ref_start = cas_fall & ras_tim_n;
  assign both_idle = ras_tim_n & cas_tim_n;
  assign refresh   = refr_q | ref_start;
  assign bank_sel  = ras_fall ? bank_addr : bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      refr_q <= 1'b0;
      bank_q <= '0;
    end else begin
      ras_q <= ras_tim_n;
      cas_q <= cas_tim_n;
      if (ras_fall) bank_q <= bank_addr;
      if (ref_start)      refr_q <= 1'b1;
      else if (both_idle) refr_q <= 1'b0;
    end
  end

  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (refr_q && !both_idle) |=> refr_q) else $error("refresh dropped early"); // R9
  AST_REF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (both_idle && !ref_start) |=> !refr_q) else $error("refresh stuck"); // R9
endmodule

// File: rtl/dss_lanes.sv
module dss_lanes
  import dss_pkg::*;
(
  input  logic             cpu_cycle,
  input  logic             rd,
  input  logic             brg_en,
  input  logic             brg_half,
  input  logic [1:0]       siz,
  input  logic [OFF_W-1:0] a_lo,
  output logic [LANES-1:0] lane_en
);
  localparam int LW   = OFF_W + 1;
  localparam int HALF = LANES / 2;

  logic [LW-1:0]    span, first, last;
  logic [LANES-1:0] cpu_mask, chip_mask, brg_keep;

  assign span  = (siz_e'(siz) == SZ_LONG) ? LW'(LANES) : LW'(siz);
  assign first = {1'b0, a_lo};
  assign last  = first + span - LW'(1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign cpu_mask[i]  = (LW'(i) >= first) && (LW'(i) <= last);
    assign chip_mask[i] = ((i >= HALF) ? 1'b1 : 1'b0) == a_lo[OFF_W-1];
    assign brg_keep[i]  = ((i >= HALF) ? 1'b1 : 1'b0) != brg_half;
  end

  always_comb begin
    if (rd)             lane_en = brg_en ? brg_keep : '1;
    else if (cpu_cycle) lane_en = cpu_mask;
    else                lane_en = chip_mask;
  end
endmodule

// File: rtl/dss_drive.sv
module dss_drive #(
  parameter int NUM_BANKS = 2,
  parameter int LANES     = 4,
  parameter int BANK_W    = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ras_tim_n,
  input  logic                 cas_tim_n,
  input  logic [BANK_W-1:0]    bank_sel,
  input  logic                 refresh,
  input  logic [LANES-1:0]     lane_en,
  output logic [NUM_BANKS-1:0] ras_n,
  output logic [LANES-1:0]     cas_n
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign ras_n[b] = ras_tim_n | ~(refresh | (bank_sel == BANK_W'(b)));
  end

  for (genvar i = 0; i < LANES; i++) begin : g_cas
    assign cas_n[i] = cas_tim_n | ~(refresh | lane_en[i]);
  end

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh |-> $countones(~ras_n) <= 1) else $error("two banks selected"); // R1
  AST_RAS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ras_tim_n |-> (&ras_n)) else $error("row select without strobe"); // R1
  AST_CAS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cas_tim_n |-> (&cas_n)) else $error("column select without strobe"); // R8
  AST_REF_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !ras_tim_n && !cas_tim_n) |-> (ras_n == '0 && cas_n == '0))
    else $error("refresh missing strobes"); // R9
endmodule

// File: rtl/dram_strobe_sel.sv
module dram_strobe_sel
  import dss_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ras_tim_n,
  input  logic                 cas_tim_n,
  input  logic [BANK_W-1:0]    bank_addr,
  input  logic                 cpu_cycle,
  input  logic                 rd,
  input  logic                 brg_en,
  input  logic                 brg_half,
  input  logic [1:0]           siz,
  input  logic [OFF_W-1:0]     a_lo,
  output logic [NUM_BANKS-1:0] ras_n,
  output logic [LANES-1:0]     cas_n
);
  localparam int HALF = LANES / 2;

  logic [BANK_W-1:0] bank_sel;
  logic              refresh;
  logic [LANES-1:0]  lane_en;

  dss_track #(.BANK_W(BANK_W)) i_track (
    .clk(clk), .rst_n(rst_n), .ras_tim_n(ras_tim_n), .cas_tim_n(cas_tim_n),
    .bank_addr(bank_addr), .bank_sel(bank_sel), .refresh(refresh)
  );

  dss_lanes i_lanes (
    .cpu_cycle(cpu_cycle), .rd(rd), .brg_en(brg_en), .brg_half(brg_half),
    .siz(siz), .a_lo(a_lo), .lane_en(lane_en)
  );

  dss_drive #(.NUM_BANKS(NUM_BANKS), .LANES(LANES), .BANK_W(BANK_W)) i_drive (
    .clk(clk), .rst_n(rst_n), .ras_tim_n(ras_tim_n), .cas_tim_n(cas_tim_n),
    .bank_sel(bank_sel), .refresh(refresh), .lane_en(lane_en),
    .ras_n(ras_n), .cas_n(cas_n)
  );

  AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_tim_n && $past(!ras_tim_n) && !refresh && $past(!refresh))
      |-> ras_n == $past(ras_n)) else $error("bank moved mid cycle"); // R2
  AST_BRIDGE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && brg_en && !refresh)
      |-> (brg_half ? (&cas_n[LANES-1:HALF]) : (&cas_n[HALF-1:0])))
    else $error("bridged half strobed"); // R7
endmodule

// File: tb/test_dram_strobe_sel.sv
module test_dram_strobe_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_tim_n = 1'b1, cas_tim_n = 1'b1;
  logic [0:0] bank_addr = '0;
  logic       cpu_cycle = 1'b0, rd = 1'b0, brg_en = 1'b0, brg_half = 1'b0;
  logic [1:0] siz = '0, a_lo = '0;
  logic [1:0] ras_n;
  logic [3:0] cas_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dram_strobe_sel i_dram_strobe_sel (
    .clk(clk), .rst_n(rst_n), .ras_tim_n(ras_tim_n), .cas_tim_n(cas_tim_n),
    .bank_addr(bank_addr), .cpu_cycle(cpu_cycle), .rd(rd), .brg_en(brg_en),
    .brg_half(brg_half), .siz(siz), .a_lo(a_lo), .ras_n(ras_n), .cas_n(cas_n)
  );

  // {cpu_cycle, rd, brg_en, brg_half, siz, a_lo, expected cas_n}
  localparam int NV = 18;
  localparam logic [11:0] VEC [NV] = '{
    {4'b1000, 2'b01, 2'd0, 4'b1110},  // R3 byte at 0
    {4'b1000, 2'b01, 2'd3, 4'b0111},  // R3 byte at 3
    {4'b1000, 2'b10, 2'd0, 4'b1100},  // R3 word at 0
    {4'b1000, 2'b10, 2'd1, 4'b1001},  // R3 word at 1
    {4'b1000, 2'b11, 2'd0, 4'b1000},  // R3 three at 0
    {4'b1000, 2'b00, 2'd0, 4'b0000},  // R3 long at 0
    {4'b1000, 2'b10, 2'd3, 4'b0111},  // R4 word cut at 3
    {4'b1000, 2'b11, 2'd2, 4'b0011},  // R4 three cut
    {4'b1000, 2'b00, 2'd1, 4'b0001},  // R4 long cut
    {4'b0000, 2'b01, 2'd0, 4'b1100},  // R5 chip low half
    {4'b0000, 2'b00, 2'd3, 4'b0011},  // R5 chip high half, a0 ignored
    {4'b1100, 2'b01, 2'd2, 4'b0000},  // R6 cpu byte read
    {4'b0100, 2'b10, 2'd0, 4'b0000},  // R6 chip read
    {4'b1110, 2'b00, 2'd0, 4'b0011},  // R7 bridge drives low half
    {4'b0111, 2'b01, 2'd1, 4'b1100},  // R7 bridge drives high half
    {4'b1010, 2'b10, 2'd0, 4'b1100},  // R7 bridge ignored on write
    {4'b1011, 2'b01, 2'd2, 4'b1011},  // R7 bridge ignored on write
    {4'b1101, 2'b11, 2'd1, 4'b0000}   // R6 non-bridged read with half set
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ras_tim_n = 1'b1; cas_tim_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 ras in reset", {2'b00, ras_n}, 4'b0011);
    chk("R10 cas in reset", cas_n, 4'b1111);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ras after reset", {2'b00, ras_n}, 4'b0011);
    chk("R10 cas after reset", cas_n, 4'b1111);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {cpu_cycle, rd, brg_en, brg_half, siz, a_lo} = VEC[v][11:4];
      bank_addr = 1'(v % 2);
      ras_tim_n = 1'b0;
      @(negedge clk);
      chk("R8 cas idle while row low", cas_n, 4'b1111);
      chk("R1 bank", {2'b00, ras_n}, (v % 2 == 1) ? 4'b0001 : 4'b0010);
      cas_tim_n = 1'b0;
      @(negedge clk);
      chk($sformatf("R3-R7 lanes vector %0d", v), cas_n, VEC[v][3:0]);
      idle();
      chk("R1 idle rows", {2'b00, ras_n}, 4'b0011);
    end

    // R2: bank held while row strobe low
    @(negedge clk);
    cpu_cycle = 1'b1; rd = 1'b0; brg_en = 1'b0; siz = 2'b01; a_lo = 2'd0;
    bank_addr = 1'b0; ras_tim_n = 1'b0;
    @(negedge clk);
    bank_addr = 1'b1;
    @(negedge clk);
    chk("R2 bank held", {2'b00, ras_n}, 4'b0010);
    cas_tim_n = 1'b0;
    @(negedge clk);
    chk("R2 bank still held", {2'b00, ras_n}, 4'b0010);
    idle();

    // R9: column-before-row refresh
    @(negedge clk);
    bank_addr = 1'b0; rd = 1'b0; siz = 2'b01; a_lo = 2'd3;
    cas_tim_n = 1'b0;
    @(negedge clk);
    chk("R9 refresh cas all", cas_n, 4'b0000);
    chk("R9 refresh ras idle", {2'b00, ras_n}, 4'b0011);
    ras_tim_n = 1'b0;
    @(negedge clk);
    chk("R9 refresh ras all", {2'b00, ras_n}, 4'b0000);
    chk("R9 refresh cas held", cas_n, 4'b0000);
    ras_tim_n = 1'b1;
    @(negedge clk);
    chk("R9 refresh persists", cas_n, 4'b0000);
    idle();
    @(negedge clk);
    bank_addr = 1'b1; siz = 2'b01; a_lo = 2'd0; ras_tim_n = 1'b0;
    @(negedge clk);
    cas_tim_n = 1'b0;
    @(negedge clk);
    chk("R9 normal after refresh ras", {2'b00, ras_n}, 4'b0001);
    chk("R9 normal after refresh cas", cas_n, 4'b1110);
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule